// File: doc/BRIEF.md
# Single-Channel Memory Copy Engine

This block moves a run of bytes from one memory region to another. Software loads a source address, a destination address and a byte count, then writes a control word. The control word sets the access width on each side, whether each address steps forward, whether each request moves everything or only one unit, whether an outside request line may trigger work, and whether finishing raises an interrupt. The engine then drives a simple one-master memory port. It issues a read, waits for its response, then a write, and so on, with one access outstanding at a time.

Work is grouped in units. A unit is as wide as the larger of the two access sizes. The engine reads enough narrow beats to fill a unit, or writes enough narrow beats to drain one. Read data is packed little-endian into a 32-bit holding register. The byte count falls by the destination width on every write. When the count reaches zero, or when a bus error is returned, the channel stops and raises a sticky done flag. Bad settings are caught before any bus access.

Register select on `regSel`: 0 control word, 1 source address, 2 destination address, 3 byte count. Control word bits: 0 start (reads back as 0), 1 interrupt enable, 2 external-request enable, 3 cycle steal, 4 auto-align, 5 source increment, 6 destination increment, 8:7 source size, 10:9 destination size. Size codes: 00 = 4 bytes, 01 = 1 byte, 10 = 2 bytes, 11 reserved.

Top module: `dma_channel_engine`

## Requirements
- R1: After reset, the control word reads 0, the addresses and the count are 0, and done, both error flags, the interrupt and `memReq` are low.
- R2: Writing the control word with bit 0 set while idle begins a transfer, whether or not the external-request enable (bit 2) is set.
- R3: A one-cycle pulse on `extReq` while idle begins a transfer only when bit 2 of the stored control word is 1. Otherwise no access occurs, `busy` stays low and the count is unchanged.
- R4: With cycle steal (bit 3) clear, the engine repeats read/write units with no further request until the count reaches 0. It then sets done. Each write carries the source bytes in order, and the count drops by the destination width per write.
- R5: With cycle steal set, each request moves exactly one unit. The engine then waits with `busy` high and `memReq` low until the next request: a start bit or an enabled `extReq`.
- R6: A start-bit write and an enabled `extReq` in the same cycle count as a single request and move a single unit.
- R7: A unit is max(source size, destination size) bytes. It takes unit/source-size reads and unit/destination-size writes. Read data is right-justified on `memRdata`, and byte i of a unit comes from the i-th byte read.
- R8: After each read the source address steps by the source size when bit 5 is set. After each write the destination address steps by the destination size when bit 6 is set. A clear bit holds the address.
- R9: With auto-align (bit 4) set, the source side is aligned when source size ≥ destination size, and the destination side otherwise. The aligned side's address steps even when its increment bit is clear.
- R10: An error response on a read or a write stops the channel at once. It sets `busErr` and done, leaves the count as it was, and issues no further access.
- R11: A request with a reserved size code, a zero count, or a count that is not a multiple of the unit size sets `cfgErr` and done without any bus access.
- R12: `irq` is high exactly while done is set and interrupt enable (bit 1) is 1. A `doneClr` pulse clears done, and a new request clears done and both error flags.
- R13: Writes to the address, count or control-field registers while `busy` is high have no effect. Only the start bit still acts, as a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regSel | input | 2 | Register select (0 control, 1 source, 2 destination, 3 count) |
| regWdata | input | 32 | Register write data |
| extReq | input | 1 | External transfer request, sampled each cycle |
| doneClr | input | 1 | Clears the done flag |
| memReq | output | 1 | Memory access request, held until answered |
| memWe | output | 1 | 1 = write access, 0 = read access |
| memAddr | output | AW | Byte address of the access |
| memSize | output | 2 | Access size code (00 word, 01 byte, 10 half) |
| memWdata | output | 32 | Right-justified write data |
| memRdata | input | 32 | Right-justified read data, valid with memAck |
| memAck | input | 1 | Access completed |
| memErr | input | 1 | Access failed |
| ctrlWord | output | 32 | Control word readback |
| curSrc | output | AW | Current source address |
| curDst | output | AW | Current destination address |
| bytesLeft | output | CW | Remaining byte count |
| busy | output | 1 | Channel active or waiting for its next request |
| done | output | 1 | Sticky completion flag |
| busErr | output | 1 | Bus error flag |
| cfgErr | output | 1 | Configuration error flag |
| irq | output | 1 | Interrupt output |

## Verification
The embedded properties assume a memory that answers each held request with `memAck` or `memErr` but never both, and that drives `memRdata` valid whenever it acknowledges a read. They also assume the memory responds only while `memReq` is high. The bench's responder keeps within this. It evaluates `memReq` half a cycle after each edge, answers in the following cycle with exactly one of the two responses, and raises an error only on the single address armed for the error test. Register writes and `extReq` pulses last one cycle and are driven on the falling edge.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    SZ_WORD = 2'b00,
    SZ_BYTE = 2'b01,
    SZ_HALF = 2'b10,
    SZ_RSVD = 2'b11
  } xfer_size_e;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_SRC   = 2'd1,
    SEL_DST   = 2'd2,
    SEL_COUNT = 2'd3
  } reg_sel_e;

  // Packed so that it maps directly onto control word bits [10:1].
  typedef struct packed {
    xfer_size_e dstSize;
    xfer_size_e srcSize;
    logic       dstInc;
    logic       srcInc;
    logic       autoAlign;
    logic       cycleSteal;
    logic       extEn;
    logic       irqEn;
  } chan_cfg_t;

  localparam int CFG_W = $bits(chan_cfg_t);

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic ldSrc;
    logic ldDst;
    logic ldCnt;
    logic rdBeat;
    logic wrBeat;
    logic offClr;
    logic srcAdv;
    logic dstAdv;
  } dp_strobe_t;

  function automatic logic [2:0] sizeBytes(xfer_size_e s);
    case (s)
      SZ_WORD: sizeBytes = 3'd4;
      SZ_BYTE: sizeBytes = 3'd1;
      SZ_HALF: sizeBytes = 3'd2;
      default: sizeBytes = 3'd0;
    endcase
  endfunction

  // Beats of width narrow needed to cover a unit of width wide.
  function automatic logic [2:0] beatRatio(logic [2:0] wide, logic [2:0] narrow);
    if (wide == narrow)                          beatRatio = 3'd1;
    else if (wide == 3'd4 && narrow == 3'd1)     beatRatio = 3'd4;
    else                                         beatRatio = 3'd2;
  endfunction

  function automatic logic [31:0] laneMask(logic [2:0] nb);
    case (nb)
      3'd1:    laneMask = 32'h0000_00FF;
      3'd2:    laneMask = 32'h0000_FFFF;
      default: laneMask = 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/dma_datapath.sv
module dma_datapath
  import dma_chan_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rstN,
  input  dp_strobe_t    stb,
  input  logic [31:0]   loadData,
  input  logic [2:0]    srcBytes,
  input  logic [2:0]    dstBytes,
  input  logic [31:0]   memRdata,
  output logic [AW-1:0] srcAddr,
  output logic [AW-1:0] dstAddr,
  output logic [CW-1:0] count,
  output logic [31:0]   wrData
);

  localparam int OFF_W = 2;

  logic [31:0]      packBuf;
  logic [OFF_W-1:0] laneOff;
  logic [4:0]       shAmt;
  logic [31:0]      rdMask;

  always_comb begin
    shAmt  = {laneOff, 3'b000};
    rdMask = laneMask(srcBytes);
    wrData = (packBuf >> shAmt) & laneMask(dstBytes);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcAddr <= '0;
      dstAddr <= '0;
      count   <= '0;
      packBuf <= '0;
      laneOff <= '0;
    end else begin
      if (stb.ldSrc)                     srcAddr <= AW'(loadData);
      else if (stb.rdBeat && stb.srcAdv) srcAddr <= srcAddr + AW'(srcBytes);

      if (stb.ldDst)                     dstAddr <= AW'(loadData);
      else if (stb.wrBeat && stb.dstAdv) dstAddr <= dstAddr + AW'(dstBytes);

      if (stb.ldCnt)                     count <= CW'(loadData);
      else if (stb.wrBeat)               count <= count - CW'(dstBytes);

      if (stb.rdBeat)
        packBuf <= (packBuf & ~(rdMask << shAmt)) | ((memRdata & rdMask) << shAmt);

      if (stb.offClr)                    laneOff <= '0;
      else if (stb.rdBeat)               laneOff <= laneOff + srcBytes[OFF_W-1:0];
      else if (stb.wrBeat)               laneOff <= laneOff + dstBytes[OFF_W-1:0];
    end
  end

  // R4: a write never takes the count below zero
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrBeat |-> (count >= CW'(dstBytes)));

  // R4: the count only moves on a load or a write beat
  a_r4_count_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.ldCnt && !stb.wrBeat) |=> (count == $past(count)));

  // R8: the source address only moves on a load or a read beat
  a_r8_src_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.ldSrc && !stb.rdBeat) |=> (srcAddr == $past(srcAddr)));

  // R8: the destination address only moves on a load or a write beat
  a_r8_dst_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.ldDst && !stb.wrBeat) |=> (dstAddr == $past(dstAddr)));

endmodule

// File: rtl/dma_sequencer.sv
module dma_sequencer
  import dma_chan_pkg::*;
#(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWe,
  input  logic [1:0]    regSel,
  input  logic [31:0]   regWdata,
  input  logic          extReq,
  input  logic          doneClr,
  input  logic          memAck,
  input  logic          memErr,
  input  logic [CW-1:0] count,
  output dp_strobe_t    stb,
  output logic [2:0]    srcBytes,
  output logic [2:0]    dstBytes,
  output logic          memReq,
  output logic          memWe,
  output logic [1:0]    memSize,
  output chan_cfg_t     cfg,
  output logic          busy,
  output logic          done,
  output logic          busErr,
  output logic          cfgErr,
  output logic          irq
);

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_PAUSE} seq_state_e;

  seq_state_e state, stNext;
  logic [2:0] beats, beatsNext;
  logic       ctrlWr, startBit, reqNow, cfgBad, srcSide;
  logic       loadCfg, setDone, setBus, setCfg, clrFlags;
  chan_cfg_t  wrCfg, effCfg;
  logic [2:0] effS, effD, effL, unitBytes;

  always_comb begin
    ctrlWr   = regWe && (regSel == SEL_CTRL);
    wrCfg    = chan_cfg_t'(regWdata[CFG_W:1]);
    effCfg   = (ctrlWr && state == ST_IDLE) ? wrCfg : cfg;
    startBit = ctrlWr && regWdata[0];
    reqNow   = startBit || (extReq && effCfg.extEn);

    effS   = sizeBytes(effCfg.srcSize);
    effD   = sizeBytes(effCfg.dstSize);
    effL   = (effS >= effD) ? effS : effD;
    cfgBad = (effCfg.srcSize == SZ_RSVD) || (effCfg.dstSize == SZ_RSVD) ||
             (count == '0) || ((count & CW'(effL - 3'd1)) != '0);

    srcBytes  = sizeBytes(cfg.srcSize);
    dstBytes  = sizeBytes(cfg.dstSize);
    srcSide   = (srcBytes >= dstBytes);
    unitBytes = srcSide ? srcBytes : dstBytes;
  end

  always_comb begin
    stNext    = state;
    beatsNext = beats;
    loadCfg   = 1'b0;
    setDone   = 1'b0;
    setBus    = 1'b0;
    setCfg    = 1'b0;
    clrFlags  = 1'b0;
    stb       = '0;
    stb.ldSrc  = regWe && (regSel == SEL_SRC)   && (state == ST_IDLE);
    stb.ldDst  = regWe && (regSel == SEL_DST)   && (state == ST_IDLE);
    stb.ldCnt  = regWe && (regSel == SEL_COUNT) && (state == ST_IDLE);
    stb.srcAdv = cfg.srcInc || (cfg.autoAlign && srcSide);
    stb.dstAdv = cfg.dstInc || (cfg.autoAlign && !srcSide);

    case (state)
      ST_IDLE: begin
        loadCfg = ctrlWr;
        if (reqNow) begin
          clrFlags = 1'b1;
          if (cfgBad) begin
            setDone = 1'b1;
            setCfg  = 1'b1;
          end else begin
            stNext     = ST_READ;
            beatsNext  = beatRatio(effL, effS);
            stb.offClr = 1'b1;
          end
        end
      end
      ST_READ: begin
        if (memErr) begin
          setDone = 1'b1;
          setBus  = 1'b1;
          stNext  = ST_IDLE;
        end else if (memAck) begin
          stb.rdBeat = 1'b1;
          if (beats == 3'd1) begin
            stb.offClr = 1'b1;
            stNext     = ST_WRITE;
            beatsNext  = beatRatio(unitBytes, dstBytes);
          end else begin
            beatsNext = beats - 3'd1;
          end
        end
      end
      ST_WRITE: begin
        if (memErr) begin
          setDone = 1'b1;
          setBus  = 1'b1;
          stNext  = ST_IDLE;
        end else if (memAck) begin
          stb.wrBeat = 1'b1;
          if (beats == 3'd1) begin
            stb.offClr = 1'b1;
            if (count == CW'(dstBytes)) begin
              setDone = 1'b1;
              stNext  = ST_IDLE;
            end else if (cfg.cycleSteal) begin
              stNext = ST_PAUSE;
            end else begin
              stNext    = ST_READ;
              beatsNext = beatRatio(unitBytes, srcBytes);
            end
          end else begin
            beatsNext = beats - 3'd1;
          end
        end
      end
      default: begin
        if (reqNow) begin
          stNext     = ST_READ;
          beatsNext  = beatRatio(unitBytes, srcBytes);
          stb.offClr = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      beats  <= '0;
      cfg    <= '0;
      done   <= 1'b0;
      busErr <= 1'b0;
      cfgErr <= 1'b0;
    end else begin
      state <= stNext;
      beats <= beatsNext;
      if (loadCfg) cfg <= wrCfg;

      if (setDone)                 done <= 1'b1;
      else if (clrFlags || doneClr) done <= 1'b0;

      if (setBus)        busErr <= 1'b1;
      else if (clrFlags) busErr <= 1'b0;

      if (setCfg)        cfgErr <= 1'b1;
      else if (clrFlags) cfgErr <= 1'b0;
    end
  end

  always_comb begin
    memReq  = (state == ST_READ) || (state == ST_WRITE);
    memWe   = (state == ST_WRITE);
    memSize = (state == ST_WRITE) ? cfg.dstSize : cfg.srcSize;
    busy    = (state != ST_IDLE);
    irq     = cfg.irqEn && done;
  end

  // R7: an unanswered access keeps its direction and size
  a_r7_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck && !memErr) |=> (memReq && $stable(memWe) && $stable(memSize)));

  // R10: an error response ends all bus activity and flags it
  a_r10_fault_halts: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memErr) |=> (!memReq && done && busErr));

  // R11: a configuration error never coexists with bus activity
  a_r11_cfg_quiet: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> !memReq);

  // R5: after a non-final unit in cycle-steal mode the bus goes quiet
  a_r5_one_unit: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && memAck && !memErr && cfg.cycleSteal && beats == 3'd1 &&
     count != CW'(dstBytes)) |=> (busy && !memReq));

endmodule

// File: rtl/dma_channel_engine.sv
module dma_channel_engine
  import dma_chan_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWe,
  input  logic [1:0]    regSel,
  input  logic [31:0]   regWdata,
  input  logic          extReq,
  input  logic          doneClr,
  output logic          memReq,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [1:0]    memSize,
  output logic [31:0]   memWdata,
  input  logic [31:0]   memRdata,
  input  logic          memAck,
  input  logic          memErr,
  output logic [31:0]   ctrlWord,
  output logic [AW-1:0] curSrc,
  output logic [AW-1:0] curDst,
  output logic [CW-1:0] bytesLeft,
  output logic          busy,
  output logic          done,
  output logic          busErr,
  output logic          cfgErr,
  output logic          irq
);

  dp_strobe_t stb;
  chan_cfg_t  cfg;
  logic [2:0] srcBytes, dstBytes;

  dma_sequencer #(.CW(CW)) u_seq (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regSel   (regSel),
    .regWdata (regWdata),
    .extReq   (extReq),
    .doneClr  (doneClr),
    .memAck   (memAck),
    .memErr   (memErr),
    .count    (bytesLeft),
    .stb      (stb),
    .srcBytes (srcBytes),
    .dstBytes (dstBytes),
    .memReq   (memReq),
    .memWe    (memWe),
    .memSize  (memSize),
    .cfg      (cfg),
    .busy     (busy),
    .done     (done),
    .busErr   (busErr),
    .cfgErr   (cfgErr),
    .irq      (irq)
  );

  dma_datapath #(.AW(AW), .CW(CW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .loadData (regWdata),
    .srcBytes (srcBytes),
    .dstBytes (dstBytes),
    .memRdata (memRdata),
    .srcAddr  (curSrc),
    .dstAddr  (curDst),
    .count    (bytesLeft),
    .wrData   (memWdata)
  );

  always_comb begin
    memAddr  = memWe ? curDst : curSrc;
    ctrlWord = {{(31-CFG_W){1'b0}}, cfg, 1'b0};
  end

endmodule

// File: tb/tb_dma_channel_engine.sv
module tb_dma_channel_engine;

  localparam int AW = 32;
  localparam int CW = 24;

  logic          clk = 1'b0;
  logic          rstN;
  logic          regWe = 1'b0;
  logic [1:0]    regSel = '0;
  logic [31:0]   regWdata = '0;
  logic          extReq = 1'b0;
  logic          doneClr = 1'b0;
  logic          memReq, memWe;
  logic [AW-1:0] memAddr;
  logic [1:0]    memSize;
  logic [31:0]   memWdata;
  logic [31:0]   memRdata;
  logic          memAck, memErr;
  logic [31:0]   ctrlWord;
  logic [AW-1:0] curSrc, curDst;
  logic [CW-1:0] bytesLeft;
  logic          busy, done, busErr, cfgErr, irq;

  dma_channel_engine #(.AW(AW), .CW(CW)) dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .extReq(extReq), .doneClr(doneClr), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memSize(memSize), .memWdata(memWdata), .memRdata(memRdata),
    .memAck(memAck), .memErr(memErr), .ctrlWord(ctrlWord), .curSrc(curSrc),
    .curDst(curDst), .bytesLeft(bytesLeft), .busy(busy), .done(done),
    .busErr(busErr), .cfgErr(cfgErr), .irq(irq)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic [31:0] addr;
    int          nb;
    logic [31:0] data;
  } wr_item_t;

  wr_item_t    expQ[$];
  logic [7:0]  mem [0:255];
  int          checkCount = 0;
  int          failCount = 0;
  int          accesses = 0;
  bit          errArm = 1'b0;
  logic [31:0] errAddr = '0;
  bit          finished = 1'b0;

  function automatic int szb(logic [1:0] code);
    case (code)
      2'b00:   return 4;
      2'b01:   return 1;
      2'b10:   return 2;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] mk(bit ie, bit ee, bit cs, bit aa, bit si, bit di,
                                     logic [1:0] ss, logic [1:0] ds);
    return {21'b0, ds, ss, di, si, aa, cs, ee, ie, 1'b0};
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Memory responder and write monitor (scoreboard consumer)
  initial begin
    memAck = 1'b0;
    memErr = 1'b0;
    memRdata = '0;
    forever begin
      @(negedge clk);
      memAck = 1'b0;
      memErr = 1'b0;
      if (rstN && memReq) begin
        accesses++;
        if (errArm && memAddr == errAddr) begin
          memErr = 1'b1;
        end else begin
          int nb;
          memAck = 1'b1;
          nb = szb(memSize);
          if (!memWe) begin
            memRdata = '0;
            for (int i = 0; i < nb; i++) memRdata[8*i +: 8] = mem[8'(memAddr + i)];
          end else begin
            logic [31:0] got;
            got = '0;
            for (int i = 0; i < nb; i++) begin
              mem[8'(memAddr + i)] = memWdata[8*i +: 8];
              got[8*i +: 8] = memWdata[8*i +: 8];
            end
            if (expQ.size() == 0) begin
              check(1'b0, "R4 unexpected write", {32'(memAddr), got}, 64'h0);
            end else begin
              wr_item_t e;
              e = expQ.pop_front();
              check(memAddr == e.addr && nb == e.nb && got == e.data,
                    "R7 write addr/size/data", {32'(memAddr), got}, {e.addr, e.data});
            end
          end
        end
      end
    end
  end

  // Driver: builds the expected writes of a transfer from the requirements
  task automatic expectXfer(logic [31:0] s0, logic [31:0] d0, bit si, bit di, bit aa,
                            logic [1:0] ss, logic [1:0] ds, int cnt);
    int s, d, l;
    bit sAdv, dAdv;
    s = szb(ss);
    d = szb(ds);
    l = (s >= d) ? s : d;
    sAdv = si || (aa && s >= d);
    dAdv = di || (aa && s < d);
    for (int u = 0; u < cnt / l; u++) begin
      logic [7:0] b [4];
      for (int j = 0; j < l / s; j++) begin
        logic [31:0] a;
        a = s0 + (sAdv ? u * l + j * s : 0);
        for (int i = 0; i < s; i++) b[j*s + i] = mem[8'(a + i)];
      end
      for (int k = 0; k < l / d; k++) begin
        wr_item_t e;
        e.addr = d0 + (dAdv ? u * l + k * d : 0);
        e.nb = d;
        e.data = '0;
        for (int i = 0; i < d; i++) e.data[8*i +: 8] = b[k*d + i];
        expQ.push_back(e);
      end
    end
  endtask

  task automatic regWrite(logic [1:0] sel, logic [31:0] data, bit withExt);
    @(negedge clk);
    regWe = 1'b1;
    regSel = sel;
    regWdata = data;
    extReq = withExt;
    @(negedge clk);
    regWe = 1'b0;
    extReq = 1'b0;
  endtask

  task automatic setRegs(logic [31:0] s0, logic [31:0] d0, logic [31:0] cnt);
    regWrite(2'd1, s0, 1'b0);
    regWrite(2'd2, d0, 1'b0);
    regWrite(2'd3, cnt, 1'b0);
  endtask

  task automatic pulse(bit isExt);
    @(negedge clk);
    if (isExt) extReq = 1'b1; else doneClr = 1'b1;
    @(negedge clk);
    extReq = 1'b0;
    doneClr = 1'b0;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (busy && n < 500) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
  endtask

  task automatic idleCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checkCount - failCount, checkCount);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int acc0;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(ctrlWord == 0, "R1 ctrlWord", 64'(ctrlWord), 0);
    check(!done && !busErr && !cfgErr && !irq, "R1 flags", {done, busErr, cfgErr, irq}, 0);
    check(!memReq && !busy, "R1 idle", {memReq, busy}, 0);
    check(bytesLeft == 0 && curSrc == 0 && curDst == 0, "R1 regs",
          {bytesLeft, curSrc}, 0);

    // R2 / R4 / R8 / R12: word to word, both incrementing, start bit with ext disabled
    setRegs(32'h10, 32'h80, 8);
    expectXfer(32'h10, 32'h80, 1, 1, 0, 2'b00, 2'b00, 8);
    regWrite(2'd0, mk(1, 0, 0, 0, 1, 1, 2'b00, 2'b00) | 32'h1, 1'b0);
    waitIdle();
    check(done == 1'b1, "R2 start bit ran transfer to done", 64'(done), 1);
    check(bytesLeft == 0, "R4 count reaches zero", 64'(bytesLeft), 0);
    check(expQ.size() == 0, "R4 all writes seen", 64'(expQ.size()), 0);
    check(curSrc == 32'h18 && curDst == 32'h88, "R8 addresses stepped",
          {curSrc, curDst}, {32'h18, 32'h88});
    check(irq == 1'b1, "R12 irq with done", 64'(irq), 1);
    check(ctrlWord == mk(1, 0, 0, 0, 1, 1, 2'b00, 2'b00), "R1 start bit reads zero",
          64'(ctrlWord), 64'(mk(1, 0, 0, 0, 1, 1, 2'b00, 2'b00)));
    pulse(1'b0);
    check(!irq && !done, "R12 doneClr drops irq", {irq, done}, 0);

    // R7: byte reads packed into word writes
    setRegs(32'h20, 32'h90, 8);
    expectXfer(32'h20, 32'h90, 1, 1, 0, 2'b01, 2'b00, 8);
    acc0 = accesses;
    regWrite(2'd0, mk(0, 0, 0, 0, 1, 1, 2'b01, 2'b00) | 32'h1, 1'b0);
    waitIdle();
    check(accesses - acc0 == 10, "R7 byte->word access count", 64'(accesses - acc0), 10);
    check(expQ.size() == 0 && curSrc == 32'h28, "R7 byte->word done",
          {32'(expQ.size()), curSrc}, {32'h0, 32'h28});

    // R7: word reads split into half writes
    setRegs(32'h30, 32'hA0, 8);
    expectXfer(32'h30, 32'hA0, 1, 1, 0, 2'b00, 2'b10, 8);
    acc0 = accesses;
    regWrite(2'd0, mk(0, 0, 0, 0, 1, 1, 2'b00, 2'b10) | 32'h1, 1'b0);
    waitIdle();
    check(accesses - acc0 == 6, "R7 word->half access count", 64'(accesses - acc0), 6);
    check(expQ.size() == 0 && curDst == 32'hA8, "R7 word->half done",
          {32'(expQ.size()), curDst}, {32'h0, 32'hA8});

    // R9: auto-align, source wider -> source steps without its increment bit
    setRegs(32'h40, 32'hB0, 4);
    expectXfer(32'h40, 32'hB0, 0, 0, 1, 2'b10, 2'b01, 4);
    regWrite(2'd0, mk(0, 0, 0, 1, 0, 0, 2'b10, 2'b01) | 32'h1, 1'b0);
    waitIdle();
    check(curSrc == 32'h44 && curDst == 32'hB0, "R9 source side aligned",
          {curSrc, curDst}, {32'h44, 32'hB0});
    check(expQ.size() == 0, "R9 source-aligned writes", 64'(expQ.size()), 0);

    // R9: auto-align, destination wider -> destination steps
    setRegs(32'h48, 32'hC0, 8);
    expectXfer(32'h48, 32'hC0, 0, 0, 1, 2'b01, 2'b00, 8);
    regWrite(2'd0, mk(0, 0, 0, 1, 0, 0, 2'b01, 2'b00) | 32'h1, 1'b0);
    waitIdle();
    check(curSrc == 32'h48 && curDst == 32'hC8, "R9 destination side aligned",
          {curSrc, curDst}, {32'h48, 32'hC8});
    check(expQ.size() == 0, "R9 dest-aligned writes", 64'(expQ.size()), 0);

    // R3: external request ignored while disabled
    setRegs(32'h50, 32'hD0, 4);
    regWrite(2'd0, mk(0, 0, 0, 0, 1, 1, 2'b00, 2'b00), 1'b0);
    acc0 = accesses;
    pulse(1'b1);
    idleCycles(5);
    check(!busy && bytesLeft == 4 && accesses == acc0, "R3 disabled ext ignored",
          {busy, 32'(bytesLeft)}, {1'b0, 32'd4});
    // R3 / R12: enabled external request starts, no irq with irqEn clear
    regWrite(2'd0, mk(0, 1, 0, 0, 1, 1, 2'b00, 2'b00), 1'b0);
    expectXfer(32'h50, 32'hD0, 1, 1, 0, 2'b00, 2'b00, 4);
    pulse(1'b1);
    waitIdle();
    check(done && expQ.size() == 0, "R3 enabled ext ran", {done, 32'(expQ.size())},
          {1'b1, 32'h0});
    check(irq == 1'b0, "R12 no irq when disabled", 64'(irq), 0);

    // R5 / R6 / R13: cycle steal, one unit per request
    setRegs(32'h60, 32'hE0, 12);
    expectXfer(32'h60, 32'hE0, 1, 1, 0, 2'b00, 2'b00, 12);
    regWrite(2'd0, mk(0, 1, 1, 0, 1, 1, 2'b00, 2'b00) | 32'h1, 1'b1);
    idleCycles(6);
    check(bytesLeft == 8, "R6 coincident requests move one unit", 64'(bytesLeft), 8);
    check(busy && !memReq, "R5 waits between units", {busy, memReq}, {1'b1, 1'b0});
    regWrite(2'd1, 32'h0, 1'b0);
    regWrite(2'd3, 32'h40, 1'b0);
    regWrite(2'd0, 32'h0, 1'b0);
    check(curSrc == 32'h64 && bytesLeft == 8, "R13 busy writes ignored",
          {curSrc, 32'(bytesLeft)}, {32'h64, 32'd8});
    check(ctrlWord == mk(0, 1, 1, 0, 1, 1, 2'b00, 2'b00), "R13 control held",
          64'(ctrlWord), 64'(mk(0, 1, 1, 0, 1, 1, 2'b00, 2'b00)));
    pulse(1'b1);
    idleCycles(6);
    check(bytesLeft == 4 && busy, "R5 ext moves one unit", {busy, 32'(bytesLeft)},
          {1'b1, 32'd4});
    regWrite(2'd0, mk(0, 1, 1, 0, 1, 1, 2'b00, 2'b00) | 32'h1, 1'b0);
    waitIdle();
    check(bytesLeft == 0 && done && expQ.size() == 0, "R5 final unit completes",
          {done, 32'(bytesLeft)}, {1'b1, 32'd0});

    // R10: error on the second read
    setRegs(32'h70, 32'hF0, 8);
    expectXfer(32'h70, 32'hF0, 1, 1, 0, 2'b00, 2'b00, 4);
    errArm = 1'b1;
    errAddr = 32'h74;
    acc0 = accesses;
    regWrite(2'd0, mk(0, 0, 0, 0, 1, 1, 2'b00, 2'b00) | 32'h1, 1'b0);
    waitIdle();
    errArm = 1'b0;
    check(busErr && done && !busy, "R10 error halts", {busErr, done, busy}, 3'b110);
    check(bytesLeft == 4 && accesses - acc0 == 3, "R10 count kept, no more access",
          {32'(bytesLeft), 32'(accesses - acc0)}, {32'd4, 32'd3});
    check(expQ.size() == 0, "R10 first unit written", 64'(expQ.size()), 0);

    // R11: count not a multiple of the unit
    setRegs(32'h10, 32'h80, 6);
    acc0 = accesses;
    regWrite(2'd0, mk(0, 0, 0, 0, 1, 1, 2'b00, 2'b00) | 32'h1, 1'b0);
    idleCycles(4);
    check(cfgErr && done && !busErr && accesses == acc0, "R11 misaligned count",
          {cfgErr, done, busErr, 32'(accesses - acc0)}, {3'b110, 32'd0});
    // R11: reserved size code
    regWrite(2'd3, 32'h8, 1'b0);
    pulse(1'b0);
    acc0 = accesses;
    regWrite(2'd0, mk(0, 0, 0, 0, 1, 1, 2'b11, 2'b00) | 32'h1, 1'b0);
    idleCycles(4);
    check(cfgErr && done && !busy && accesses == acc0, "R11 reserved size",
          {cfgErr, done, busy, 32'(accesses - acc0)}, {3'b110, 32'd0});

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule